// File: doc/BRIEF.md
# Scanline Sprite Evaluation Unit

This block picks out the sprites that appear on the coming video line. A start pulse arrives during each visible line, together with the line number to test and the sprite height mode. The block then fills the 32-byte secondary sprite store with 0xFF. Next it walks the 64-entry primary sprite table in ascending index order, reading one byte per cycle through a read port with one cycle of latency. Each sprite whose vertical span covers the target line is copied, all four bytes of it, into the next free secondary slot. The output units that load from the secondary store therefore receive sprites in table order. Copying stops after eight sprites.

Each primary entry is four bytes at addresses idx*4+0..3: top line minus one, tile, attributes, horizontal position. A flag records whether sprite 0 was among the sprites selected. A second flag holds the value seen by the current line. The line-boundary pulse loads that second flag, so an evaluation running for the next line never disturbs the flag that the hit logic of the current line reads.

Top module: `sprite_eval_unit`

## Requirements
- R1: After reset, spr_count is 0, spr0_next, spr0_cur and eval_done are low, and sec_we is low.
- R2: After eval_start, every secondary byte (addresses 0 to 31) is written with 0xFF before any sprite byte is copied, so a slot left unfilled reads 0xFF.
- R3: Sprite i is in range when the 9-bit unsigned difference eval_line minus its byte 0 is below the height, which is 8 with tall_mode low and 16 with tall_mode high. eval_line and tall_mode are sampled with eval_start.
- R4: Sprites in range are copied in ascending primary index order into slots 0, 1, 2, and so on. Byte b of primary entry i (address i*4+b) goes to secondary address slot*4+b.
- R5: Byte 1 is the tile, byte 2 the attributes and byte 3 the X position. Bytes 0, 1 and 3 are copied unchanged. Byte 2 is written ANDed with 0xE3.
- R6: At most 8 sprites are copied. In-range sprites after the eighth leave the secondary store untouched, and spr_count ends at min(8, number in range).
- R7: When evaluation ends, spr0_next is high exactly when sprite 0 is in range. eval_start clears it.
- R8: A line_end pulse loads spr0_cur from spr0_next. Otherwise spr0_cur holds, and evaluation does not change it.
- R9: eval_done rises no more than 200 cycles after eval_start and stays high until the next eval_start. While it is high, sec_we is low.
- R10: eval_start during an evaluation abandons it and starts over with the newly sampled line and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_start | input | 1 | Starts an evaluation pass |
| eval_line | input | 8 | Line number to test sprites against |
| tall_mode | input | 1 | 1 selects 16-line sprites, 0 selects 8-line |
| line_end | input | 1 | Line boundary pulse, loads the current-line sprite 0 flag |
| pri_addr | output | 8 | Primary table read address |
| pri_rdata | input | 8 | Primary read data, one cycle after the address |
| sec_we | output | 1 | Secondary store write enable |
| sec_addr | output | 5 | Secondary store write address |
| sec_wdata | output | 8 | Secondary store write data |
| spr_count | output | 4 | Number of sprites copied so far |
| spr0_next | output | 1 | Sprite 0 selected for the next line |
| spr0_cur | output | 1 | Sprite 0 present on the current line |
| eval_done | output | 1 | Evaluation finished |

## Verification
The hardest cases to reach are the eight-sprite cutoff and the range edges, where a sprite sits exactly 7/8 or 15/16 lines above the target. The bench loads tables with dense clusters of identical Y values and sweeps the target line across each cluster in both height modes. Every line is then compared with a model that computes the in-range test arithmetically. To check that the two-stage flag stays isolated, the bench lets an evaluation with a different sprite 0 result finish before the line_end pulse and observes spr0_cur in between. Another test restarts an evaluation midway through.

// File: rtl/sev_pkg.sv
package sev_pkg;
  localparam int unsigned BYTES_PER_SPR = 4;
  localparam int unsigned BYTE_W        = 8;
  localparam logic [7:0]  ATTR_KEEP     = 8'hE3;
  localparam logic [7:0]  FILL_BYTE     = 8'hFF;
  localparam int unsigned SHORT_H       = 8;
  localparam int unsigned TALL_H        = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_FETCH = 3'd2,
    ST_TEST  = 3'd3,
    ST_COPY  = 3'd4,
    ST_DONE  = 3'd5
  } sev_state_e;
endpackage

// File: rtl/sev_reset_sync.sv
module sev_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sev_range_check.sv
module sev_range_check #(
  parameter int unsigned LINE_W = 8
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] top_y,
  input  logic              tall,
  output logic              in_range
);
  import sev_pkg::*;

  logic [LINE_W:0] diff;
  logic [LINE_W:0] height;

  always_comb begin
    diff     = {1'b0, line_num} - {1'b0, top_y};
    height   = tall ? (LINE_W+1)'(TALL_H) : (LINE_W+1)'(SHORT_H);
    in_range = !diff[LINE_W] && (diff < height);
  end
endmodule

// File: rtl/sev_line_flags.sv
module sev_line_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic line_end,
  input  logic next_flag,
  output logic cur_flag
);
  logic cur_q;
  logic cur_d;

  always_comb begin
    cur_d = cur_q;
    if (line_end) cur_d = next_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= 1'b0;
    else        cur_q <= cur_d;
  end

  assign cur_flag = cur_q;
endmodule

// File: rtl/sev_sequencer.sv
module sev_sequencer #(
  parameter int unsigned NUM_SPR = 64,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned LINE_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SPR),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned PRI_AW = IDX_W + 2,
  localparam int unsigned SEC_AW = SLOT_W + 2,
  localparam int unsigned CNT_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_start,
  input  logic [LINE_W-1:0] eval_line,
  input  logic              tall_mode,
  output logic [PRI_AW-1:0] pri_addr,
  input  logic [7:0]        pri_rdata,
  output logic              sec_we,
  output logic [SEC_AW-1:0] sec_addr,
  output logic [7:0]        sec_wdata,
  output logic [CNT_W-1:0]  found_cnt,
  output logic              spr0_found,
  output logic              done
);
  import sev_pkg::*;

  localparam logic [SEC_AW-1:0] LAST_SEC = SEC_AW'(SLOTS*BYTES_PER_SPR - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_SPR - 1);
  localparam logic [CNT_W-1:0]  LAST_SLT = CNT_W'(SLOTS - 1);

  sev_state_e        state_q, state_d;
  logic [SEC_AW-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        byte_q, byte_d;
  logic [CNT_W-1:0]  slot_q, slot_d;
  logic              s0_q, s0_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              tall_q, tall_d;
  logic              hit;

  sev_range_check #(.LINE_W(LINE_W)) u_range (
    .line_num (line_q),
    .top_y    (pri_rdata[LINE_W-1:0]),
    .tall     (tall_q),
    .in_range (hit)
  );

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    idx_d     = idx_q;
    byte_d    = byte_q;
    slot_d    = slot_q;
    s0_d      = s0_q;
    line_d    = line_q;
    tall_d    = tall_q;
    sec_we    = 1'b0;
    sec_addr  = '0;
    sec_wdata = '0;
    pri_addr  = {idx_q, 2'b00};
    if (eval_start) begin
      state_d = ST_CLEAR;
      ptr_d   = '0;
      idx_d   = '0;
      byte_d  = '0;
      slot_d  = '0;
      s0_d    = 1'b0;
      line_d  = eval_line;
      tall_d  = tall_mode;
    end else begin
      case (state_q)
        ST_CLEAR: begin
          sec_we    = 1'b1;
          sec_addr  = ptr_q;
          sec_wdata = FILL_BYTE;
          ptr_d     = ptr_q + 1'b1;
          if (ptr_q == LAST_SEC) begin
            state_d = ST_FETCH;
            idx_d   = '0;
          end
        end
        ST_FETCH: begin
          state_d = ST_TEST;
        end
        ST_TEST: begin
          if (hit) begin
            sec_we    = 1'b1;
            sec_addr  = {slot_q[SLOT_W-1:0], 2'b00};
            sec_wdata = pri_rdata;
            pri_addr  = {idx_q, 2'b01};
            byte_d    = 2'd1;
            state_d   = ST_COPY;
            if (idx_q == '0) s0_d = 1'b1;
          end else if (idx_q == LAST_IDX) begin
            state_d = ST_DONE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_FETCH;
          end
        end
        ST_COPY: begin
          sec_we    = 1'b1;
          sec_addr  = {slot_q[SLOT_W-1:0], byte_q};
          sec_wdata = (byte_q == 2'd2) ? (pri_rdata & ATTR_KEEP) : pri_rdata;
          if (byte_q != 2'd3) begin
            pri_addr = {idx_q, byte_q + 2'd1};
            byte_d   = byte_q + 2'd1;
          end else begin
            slot_d = slot_q + 1'b1;
            byte_d = 2'd0;
            if (slot_q == LAST_SLT || idx_q == LAST_IDX) begin
              state_d = ST_DONE;
            end else begin
              idx_d   = idx_q + 1'b1;
              state_d = ST_FETCH;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
      byte_q  <= '0;
      slot_q  <= '0;
      s0_q    <= 1'b0;
      line_q  <= '0;
      tall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      byte_q  <= byte_d;
      slot_q  <= slot_d;
      s0_q    <= s0_d;
      line_q  <= line_d;
      tall_q  <= tall_d;
    end
  end

  assign found_cnt  = slot_q;
  assign spr0_found = s0_q;
  assign done       = (state_q == ST_DONE);
endmodule

// File: rtl/sprite_eval_unit.sv
module sprite_eval_unit #(
  parameter int unsigned NUM_SPR = 64,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned LINE_W  = 8,
  localparam int unsigned PRI_AW = $clog2(NUM_SPR) + 2,
  localparam int unsigned SEC_AW = $clog2(SLOTS) + 2,
  localparam int unsigned CNT_W  = $clog2(SLOTS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_start,
  input  logic [LINE_W-1:0] eval_line,
  input  logic              tall_mode,
  input  logic              line_end,
  output logic [PRI_AW-1:0] pri_addr,
  input  logic [7:0]        pri_rdata,
  output logic              sec_we,
  output logic [SEC_AW-1:0] sec_addr,
  output logic [7:0]        sec_wdata,
  output logic [CNT_W-1:0]  spr_count,
  output logic              spr0_next,
  output logic              spr0_cur,
  output logic              eval_done
);
  logic rst_sync_n;

  sev_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sev_sequencer #(
    .NUM_SPR (NUM_SPR),
    .SLOTS   (SLOTS),
    .LINE_W  (LINE_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .eval_start (eval_start),
    .eval_line  (eval_line),
    .tall_mode  (tall_mode),
    .pri_addr   (pri_addr),
    .pri_rdata  (pri_rdata),
    .sec_we     (sec_we),
    .sec_addr   (sec_addr),
    .sec_wdata  (sec_wdata),
    .found_cnt  (spr_count),
    .spr0_found (spr0_next),
    .done       (eval_done)
  );

  sev_line_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .line_end  (line_end),
    .next_flag (spr0_next),
    .cur_flag  (spr0_cur)
  );
endmodule

// File: rtl/sprite_eval_unit_chk.sv
module sprite_eval_unit_chk #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eval_start,
  input logic             line_end,
  input logic             sec_we,
  input logic [CNT_W-1:0] spr_count,
  input logic             spr0_next,
  input logic             spr0_cur,
  input logic             eval_done
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    spr_count <= CNT_W'(SLOTS));                                           // R6
  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_start |=> spr_count >= $past(spr_count));                        // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eval_start |=> (spr_count == '0) && !spr0_next && !eval_done);         // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eval_done |-> !sec_we);                                                // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_done && !eval_start) |=> eval_done);                             // R9
  AST_CUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> spr0_cur == $past(spr0_next));                            // R8
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(spr0_cur));                                      // R8
endmodule

bind sprite_eval_unit sprite_eval_unit_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eval_start (eval_start),
  .line_end   (line_end),
  .sec_we     (sec_we),
  .spr_count  (spr_count),
  .spr0_next  (spr0_next),
  .spr0_cur   (spr0_cur),
  .eval_done  (eval_done)
);

// File: tb/sprite_eval_unit_bench.sv
module sprite_eval_unit_bench;
  logic       clk;
  logic       rst_n;
  logic       eval_start;
  logic [7:0] eval_line;
  logic       tall_mode;
  logic       line_end;
  logic [7:0] pri_addr;
  logic [7:0] pri_rdata;
  logic       sec_we;
  logic [4:0] sec_addr;
  logic [7:0] sec_wdata;
  logic [3:0] spr_count;
  logic       spr0_next;
  logic       spr0_cur;
  logic       eval_done;

  logic [7:0] oam [256];
  logic [7:0] sec [32];
  logic [7:0] exp_sec [32];
  int         exp_cnt;
  int         exp_s0;
  int         n_tests;
  int         n_fail;

  sprite_eval_unit u_sprite_eval_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_start (eval_start),
    .eval_line  (eval_line),
    .tall_mode  (tall_mode),
    .line_end   (line_end),
    .pri_addr   (pri_addr),
    .pri_rdata  (pri_rdata),
    .sec_we     (sec_we),
    .sec_addr   (sec_addr),
    .sec_wdata  (sec_wdata),
    .spr_count  (spr_count),
    .spr0_next  (spr0_next),
    .spr0_cur   (spr0_cur),
    .eval_done  (eval_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    pri_rdata <= oam[pri_addr];
    if (sec_we) sec[sec_addr] <= sec_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic fill_oam(input int kind);
    for (int i = 0; i < 64; i++) begin
      case (kind)
        0: oam[4*i] = 8'(i * 4);
        1: oam[4*i] = 8'(100 + (i % 4));
        2: oam[4*i] = 8'(8'hEF + (i % 17));
        default: oam[4*i] = 8'hFF;
      endcase
      oam[4*i+1] = 8'(i ^ 8'h5A);
      oam[4*i+2] = 8'(i * 37 + 3);
      oam[4*i+3] = 8'(255 - i);
    end
  endtask

  task automatic model(input int line, input int tall);
    int h;
    h = tall ? 16 : 8;
    exp_cnt = 0;
    exp_s0  = 0;
    for (int b = 0; b < 32; b++) exp_sec[b] = 8'hFF;
    for (int i = 0; i < 64; i++) begin
      int d;
      d = line - int'(oam[4*i]);
      if (d >= 0 && d < h && exp_cnt < 8) begin
        if (i == 0) exp_s0 = 1;
        exp_sec[4*exp_cnt]   = oam[4*i];
        exp_sec[4*exp_cnt+1] = oam[4*i+1];
        exp_sec[4*exp_cnt+2] = oam[4*i+2] & 8'hE3;
        exp_sec[4*exp_cnt+3] = oam[4*i+3];
        exp_cnt++;
      end
    end
  endtask

  task automatic launch(input int line, input int tall);
    @(negedge clk);
    eval_line  = 8'(line);
    tall_mode  = tall[0];
    eval_start = 1'b1;
    @(negedge clk);
    eval_start = 1'b0;
  endtask

  task automatic finish_and_check(input int line, input int tall);
    int cyc;
    int bad;
    cyc = 1;
    while (!eval_done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc <= 200, "R9 done latency", cyc, 200);
    model(line, tall);
    bad = -1;
    for (int b = 0; b < 32; b++) if (sec[b] !== exp_sec[b] && bad < 0) bad = b;
    if (bad < 0) check(1'b1, "R2 R4 R5 secondary", 0, 0);
    else check(1'b0, "R2 R3 R4 R5 secondary byte", int'(sec[bad]), int'(exp_sec[bad]));
    check(int'(spr_count) == exp_cnt, "R3 R6 count", int'(spr_count), exp_cnt);
    check(int'(spr0_next) == exp_s0, "R7 sprite0 next", int'(spr0_next), exp_s0);
  endtask

  task automatic run_eval(input int line, input int tall);
    launch(line, tall);
    finish_and_check(line, tall);
  endtask

  task automatic pulse_line_end;
    @(negedge clk);
    line_end = 1'b1;
    @(negedge clk);
    line_end = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    n_tests    = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    eval_start = 1'b0;
    eval_line  = '0;
    tall_mode  = 1'b0;
    line_end   = 1'b0;
    fill_oam(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(spr_count == 0 && !spr0_next && !spr0_cur && !eval_done && !sec_we,
          "R1 reset", {spr_count, spr0_next, spr0_cur, eval_done, sec_we}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(spr_count == 0 && !eval_done && !sec_we, "R1 idle after reset",
          {spr_count, eval_done, sec_we}, 0);

    // R3 R4 sweep over spaced table, both heights
    for (int t = 0; t < 2; t++)
      for (int ln = 0; ln < 256; ln += 2) run_eval(ln, t);

    // R6 dense cluster, more than 8 in range
    fill_oam(1);
    for (int t = 0; t < 2; t++)
      for (int ln = 95; ln <= 125; ln++) run_eval(ln, t);

    // R3 hidden Y values
    fill_oam(2);
    for (int t = 0; t < 2; t++)
      for (int ln = 0; ln < 239; ln += 17) run_eval(ln, t);

    // R3 edges around sprite 0 at Y=50
    fill_oam(3);
    oam[0] = 8'd50;
    run_eval(57, 0);
    run_eval(58, 0);
    run_eval(65, 1);
    run_eval(66, 1);
    run_eval(49, 1);

    // R8 two-stage flag: load, then evaluate a different result, then load
    run_eval(50, 0);
    pulse_line_end();
    check(spr0_cur == 1'b1, "R8 cur loaded", int'(spr0_cur), 1);
    run_eval(80, 0);
    check(spr0_cur == 1'b1, "R8 cur held through evaluation", int'(spr0_cur), 1);
    pulse_line_end();
    check(spr0_cur == 1'b0, "R8 cur reloaded", int'(spr0_cur), 0);
    repeat (4) @(negedge clk);
    check(spr0_cur == 1'b0 && eval_done, "R8 R9 hold while idle", {spr0_cur, eval_done}, 1);

    // R10 restart midway
    fill_oam(1);
    launch(101, 1);
    repeat (60) @(negedge clk);
    launch(103, 0);
    finish_and_check(103, 0);
    launch(100, 0);
    repeat (5) @(negedge clk);
    launch(110, 1);
    finish_and_check(110, 1);

    summary();
  end
endmodule